// File: doc/BRIEF.md
# Reset and Stop-Wakeup Sequencer

This block steps a processor core through its power states: it holds the core in reset, waits for the oscillator to settle, lets the core boot, and then manages two low-power states. One is an idle state in which the core clock keeps running. The other is a halted-clock state that needs a fresh settling delay when it is left. Each exit from reset or from a low-power state ends in a one-cycle `fetch_start` pulse, which tells the core that instruction fetch may begin.

The settling delay has two lengths, chosen by the `stab_short` mode bit. The long count is a parameter. It is applied after a power-on reset, and again when the halted-clock state is left on an interrupt request. The block drives `bus_en`, which tristates the external address, data and control pins. This output falls without waiting for a clock edge whenever the external reset is low.

The external reset and the active-low interrupt request each pass through a two-flop synchronizer. Every cycle count below is measured from the input pin and includes that synchronizer latency. Each count is the number of rising clock edges that follow the pin change, up to and including the edge after which the output is high.

Top module: `rst_wake_seq`

## Requirements
- R1: `bus_en` is 0 whenever `rst_n` is 0, within the same cycle and before any clock edge. `bus_en` is 1 from the start of the boot phase, and it is 1 whenever `fetch_start` is 1.
- R2: After `rst_n` rises, with `por_n` high and no settling pending, `fetch_start` goes high after the 33rd rising edge and not before.
- R3: After `por_n` rises, with `rst_n` held high, `fetch_start` goes high after edge S+31. S is 128 when `stab_short`=1 and LONG_STAB when `stab_short`=0.
- R4: In the halted-clock state, a qualified request ends the state. `irq_n` low is an asserted request. `fetch_start` and `irq_take` go high and `halt_clk` goes low after edge 12 (`stab_short`=1) or edge LONG_STAB (`stab_short`=0), counted from the fall of `irq_n`. The count is the same for `irq_edge`=1 (edge sense) and for `irq_edge`=0 (level sense).
- R5: In the halted-clock state, an `irq_n` low that is sampled on only one rising edge is ignored: `halt_clk` stays 1 and `fetch_start` stays 0. A request must be sampled low on two consecutive rising edges before it can end the halted-clock state.
- R6: In the idle state, `halt_clk` stays 0. After `irq_n` falls, `fetch_start` and `irq_take` go high after the 13th rising edge.
- R7: In the run state with `irq_edge`=1, an `irq_n` low sampled on two consecutive edges gives exactly one `irq_take` pulse, after the 4th edge. A low sampled on only one edge gives no pulse. With `irq_edge`=0, `irq_take` is high from the 3rd edge after `irq_n` falls until 2 edges after `irq_n` rises.
- R8: A `stop_req` sampled in the run state sets `halt_clk` after that edge. `stop_req` takes priority over `wait_req`, and `halt_clk` never rises without `stop_req` on the edge that set it.
- R9: The state register is one-hot at all times. `fetch_start` is never high for two cycles in a row.
- R10: Lowering `rst_n` while the clock is halted clears `halt_clk` after the next rising edge. The block then reboots with the count of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sequencer clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; arms the settling delay |
| rst_n | input | 1 | External reset, active low, asynchronous |
| irq_n | input | 1 | Interrupt request, active low |
| irq_edge | input | 1 | 1 = edge-sensitive request, 0 = level-sensitive request |
| stab_short | input | 1 | Settling mode: 1 = short count, 0 = long count |
| stop_req | input | 1 | Core asks to enter the halted-clock state |
| wait_req | input | 1 | Core asks to enter the idle state |
| bus_en | output | 1 | External address, data and control drivers enabled |
| halt_clk | output | 1 | Core clock is halted |
| fetch_start | output | 1 | One-cycle pulse: instruction fetch may begin |
| irq_take | output | 1 | Interrupt request accepted |

## Verification
The bench builds the block with LONG_STAB set to 600 and keeps every other parameter at its default. This brings the long-count paths, the power-on settling and the halted-clock wake with `stab_short`=0, within a few hundred cycles. The bench can therefore check those exact edge counts (600 and 631) alongside the short ones (12, 13, 33 and 159). The short counts and the two-sample qualification do not depend on LONG_STAB, so they are checked at their default values.

// File: rtl/rsw_pkg.sv
package rsw_pkg;

    typedef enum logic [5:0] {
        ST_RESET = 6'b000001,
        ST_STAB  = 6'b000010,
        ST_BOOT  = 6'b000100,
        ST_RUN   = 6'b001000,
        ST_WAIT  = 6'b010000,
        ST_STOP  = 6'b100000
    } seq_state_e;

endpackage

// File: rtl/rsw_sync.sv
module rsw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) ff_q <= '0;
                else         ff_q <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) ff_q <= '0;
                else         ff_q <= {ff_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = ff_q[STAGES-1];
endmodule

// File: rtl/rsw_irq_qual.sv
// Marks a synchronized request that has been seen on two consecutive edges.
module rsw_irq_qual (
    input  logic clk,
    input  logic arst_n,
    input  logic req_s,
    output logic seen2
);
    logic prev_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) prev_q <= 1'b0;
        else         prev_q <= req_s;
    end

    assign seen2 = req_s & prev_q;
endmodule

// File: rtl/rst_wake_seq.sv
module rst_wake_seq #(
    parameter int LONG_STAB   = 275000,
    parameter int RST_SHORT   = 128,
    parameter int WAKE_SHORT  = 12,
    parameter int BOOT_CYC    = 33,
    parameter int WAIT_WAKE   = 13,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_n,
    input  logic irq_n,
    input  logic irq_edge,
    input  logic stab_short,
    input  logic stop_req,
    input  logic wait_req,
    output logic bus_en,
    output logic halt_clk,
    output logic fetch_start,
    output logic irq_take
);
    import rsw_pkg::*;

    localparam int CNT_W      = $clog2(LONG_STAB + 1);
    // thresholds fold in synchronizer and qualifier latency
    localparam int BOOT_LAST  = BOOT_CYC - SYNC_STAGES - 2;
    localparam int WAKE_LAST_S = WAKE_SHORT - SYNC_STAGES - 3;
    localparam int WAKE_LAST_L = LONG_STAB - SYNC_STAGES - 3;
    localparam int WAIT_LAST  = WAIT_WAKE - SYNC_STAGES - 3;
    localparam int POR_LAST_S = RST_SHORT - 1;
    localparam int POR_LAST_L = LONG_STAB - 1;

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             cold;
        logic             armed;
        logic             taken;
        logic             halt;
        logic             bus;
        logic             fetch;
        logic             take;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic rst_arst_n;
    logic rst_ok;
    logic irq_s;
    logic irq_seen2;
    logic wake_ok;
    logic [CNT_W-1:0] stab_last;
    logic [5:0] state_vec;

    assign rst_arst_n = rst_n & por_n;

    rsw_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
        .clk    (clk),
        .arst_n (rst_arst_n),
        .d      (1'b1),
        .q      (rst_ok)
    );

    rsw_sync #(.STAGES(SYNC_STAGES)) u_irq_sync (
        .clk    (clk),
        .arst_n (por_n),
        .d      (~irq_n),
        .q      (irq_s)
    );

    rsw_irq_qual u_irq_qual (
        .clk    (clk),
        .arst_n (por_n),
        .req_s  (irq_s),
        .seen2  (irq_seen2)
    );

    // an edge request already served must be released before it counts again
    assign wake_ok = irq_seen2 & (~irq_edge | ~r_q.taken);

    always_comb begin
        if (r_q.cold) begin
            stab_last = stab_short ? CNT_W'(POR_LAST_S) : CNT_W'(POR_LAST_L);
        end else begin
            stab_last = stab_short ? CNT_W'(WAKE_LAST_S) : CNT_W'(WAKE_LAST_L);
        end
    end

    always_comb begin
        r_d       = r_q;
        r_d.fetch = 1'b0;
        r_d.take  = 1'b0;
        if (!irq_s) r_d.taken = 1'b0;

        unique case (r_q.state)
            ST_RESET: begin
                r_d.bus   = 1'b0;
                r_d.halt  = 1'b0;
                r_d.armed = 1'b0;
                r_d.cnt   = '0;
                if (rst_ok) begin
                    r_d.state = ST_BOOT;
                    r_d.bus   = 1'b1;
                end
            end
            ST_STAB: begin
                if (!r_q.cold && !rst_ok) begin
                    r_d.state = ST_RESET;
                    r_d.halt  = 1'b0;
                    r_d.bus   = 1'b0;
                end else if (r_q.cnt >= stab_last) begin
                    r_d.cnt = '0;
                    if (r_q.cold) begin
                        r_d.state = ST_RESET;
                        r_d.cold  = 1'b0;
                    end else begin
                        r_d.state = ST_RUN;
                        r_d.halt  = 1'b0;
                        r_d.fetch = 1'b1;
                        r_d.take  = 1'b1;
                        r_d.taken = 1'b1;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            ST_BOOT: begin
                if (!rst_ok) begin
                    r_d.state = ST_RESET;
                    r_d.bus   = 1'b0;
                end else if (r_q.cnt >= CNT_W'(BOOT_LAST)) begin
                    r_d.state = ST_RUN;
                    r_d.cnt   = '0;
                    r_d.fetch = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            ST_RUN: begin
                if (!rst_ok) begin
                    r_d.state = ST_RESET;
                    r_d.bus   = 1'b0;
                end else begin
                    if (irq_edge) begin
                        if (irq_seen2 && !r_q.taken) begin
                            r_d.take  = 1'b1;
                            r_d.taken = 1'b1;
                        end
                    end else begin
                        r_d.take = irq_s;
                    end
                    if (stop_req) begin
                        r_d.state = ST_STOP;
                        r_d.halt  = 1'b1;
                    end else if (wait_req) begin
                        r_d.state = ST_WAIT;
                        r_d.armed = 1'b0;
                        r_d.cnt   = '0;
                    end
                end
            end
            ST_WAIT: begin
                if (!rst_ok) begin
                    r_d.state = ST_RESET;
                    r_d.bus   = 1'b0;
                end else if (!r_q.armed) begin
                    if (wake_ok) begin
                        r_d.armed = 1'b1;
                        r_d.cnt   = '0;
                    end
                end else if (r_q.cnt >= CNT_W'(WAIT_LAST)) begin
                    r_d.state = ST_RUN;
                    r_d.armed = 1'b0;
                    r_d.cnt   = '0;
                    r_d.fetch = 1'b1;
                    r_d.take  = 1'b1;
                    r_d.taken = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            ST_STOP: begin
                if (!rst_ok) begin
                    r_d.state = ST_RESET;
                    r_d.halt  = 1'b0;
                    r_d.bus   = 1'b0;
                end else if (wake_ok) begin
                    r_d.state = ST_STAB;
                    r_d.cold  = 1'b0;
                    r_d.cnt   = '0;
                end
            end
            default: begin
                r_d.state = ST_RESET;
            end
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            r_q.state <= ST_STAB;
            r_q.cnt   <= '0;
            r_q.cold  <= 1'b1;
            r_q.armed <= 1'b0;
            r_q.taken <= 1'b0;
            r_q.halt  <= 1'b0;
            r_q.bus   <= 1'b0;
            r_q.fetch <= 1'b0;
            r_q.take  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_vec   = r_q.state;
    assign bus_en      = rst_n & r_q.bus;
    assign halt_clk    = r_q.halt;
    assign fetch_start = r_q.fetch;
    assign irq_take    = r_q.take;
endmodule

// File: rtl/rsw_checker.sv
module rsw_checker (
    input logic       clk,
    input logic       por_n,
    input logic       rst_n,
    input logic       stop_req,
    input logic       bus_en,
    input logic       halt_clk,
    input logic       fetch_start,
    input logic       rst_ok,
    input logic       irq_seen2,
    input logic [5:0] state_vec
);
    localparam logic [5:0] S_STAB = 6'b000010;
    localparam logic [5:0] S_STOP = 6'b100000;

    AST_FETCH_DRIVES_BUS: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        fetch_start |-> bus_en); // R1

    AST_FETCH_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
        fetch_start |=> !fetch_start); // R9

    AST_STATE_ONE_HOT: assert property (@(posedge clk) disable iff (!por_n)
        $countones(state_vec) == 1); // R9

    AST_HALT_NEEDS_STOP_REQ: assert property (@(posedge clk) disable iff (!por_n)
        $rose(halt_clk) |-> $past(stop_req)); // R8

    AST_WAKE_QUALIFIED: assert property (@(posedge clk) disable iff (!por_n)
        (state_vec == S_STAB && $past(state_vec) == S_STOP) |-> $past(irq_seen2)); // R5

    AST_RESET_CLEARS_HALT: assert property (@(posedge clk) disable iff (!por_n)
        !rst_ok |=> !halt_clk); // R10
endmodule

bind rst_wake_seq rsw_checker u_rsw_checker (
    .clk         (clk),
    .por_n       (por_n),
    .rst_n       (rst_n),
    .stop_req    (stop_req),
    .bus_en      (bus_en),
    .halt_clk    (halt_clk),
    .fetch_start (fetch_start),
    .rst_ok      (rst_ok),
    .irq_seen2   (irq_seen2),
    .state_vec   (state_vec)
);

// File: tb/rst_wake_seq_test.sv
module rst_wake_seq_test;
    localparam int LONG = 600;

    logic clk = 1'b0;
    logic por_n, rst_n, irq_n, irq_edge, stab_short, stop_req, wait_req;
    logic bus_en, halt_clk, fetch_start, irq_take;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    rst_wake_seq #(.LONG_STAB(LONG)) uut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .irq_n(irq_n),
        .irq_edge(irq_edge), .stab_short(stab_short), .stop_req(stop_req),
        .wait_req(wait_req), .bus_en(bus_en), .halt_clk(halt_clk),
        .fetch_start(fetch_start), .irq_take(irq_take)
    );

    typedef struct packed {
        logic is_wait;
        logic short_m;
        logic edge_m;
        int   exp_edges;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b1, 1'b1, 12},
        '{1'b0, 1'b1, 1'b0, 12},
        '{1'b0, 1'b0, 1'b1, LONG},
        '{1'b0, 1'b0, 1'b0, LONG},
        '{1'b1, 1'b1, 1'b1, 13},
        '{1'b1, 1'b0, 1'b0, 13}
    };

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic measure(input int limit, output int edges);
        edges = 0;
        for (int i = 0; i < limit; i++) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            if (fetch_start) return;
        end
        edges = -1;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    int e;
    int pulses;
    int first_at;

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        por_n = 1'b0; rst_n = 1'b1; irq_n = 1'b1; irq_edge = 1'b1;
        stab_short = 1'b1; stop_req = 1'b0; wait_req = 1'b0;
        cycles(3);
        check(!bus_en && !halt_clk && !fetch_start, "R1 reset state", {bus_en, halt_clk, fetch_start}, 0);

        // R3 short power-on settling
        por_n = 1'b1;
        measure(3000, e);
        check(e == 128 + 31, "R3 short por", e, 159);
        check(bus_en == 1'b1, "R1 bus on at fetch", bus_en, 1);
        cycles(1);
        check(!fetch_start, "R9 single pulse", fetch_start, 0);

        // R7 edge sense in run: two-sample request
        irq_edge = 1'b1; irq_n = 1'b0;
        pulses = 0; first_at = 0;
        for (int i = 1; i <= 8; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (i == 2) irq_n = 1'b1;
            if (irq_take) begin pulses++; if (first_at == 0) first_at = i; end
        end
        check(pulses == 1, "R7 edge pulse count", pulses, 1);
        check(first_at == 4, "R7 edge pulse edge", first_at, 4);

        // R7 single-sample request gives nothing
        irq_n = 1'b0;
        pulses = 0;
        for (int i = 1; i <= 8; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (i == 1) irq_n = 1'b1;
            if (irq_take) pulses++;
        end
        check(pulses == 0, "R7 short pulse ignored", pulses, 0);

        // R7 level sense follows the request
        irq_edge = 1'b0; irq_n = 1'b0;
        pulses = 0; first_at = 0;
        for (int i = 1; i <= 10; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (i == 5) irq_n = 1'b1;
            if (irq_take) begin pulses++; if (first_at == 0) first_at = i; end
        end
        check(pulses == 5 && first_at == 3, "R7 level window", pulses * 100 + first_at, 503);

        // R4 / R6 table of wake vectors
        foreach (VECS[k]) begin
            stab_short = VECS[k].short_m;
            irq_edge   = VECS[k].edge_m;
            if (VECS[k].is_wait) wait_req = 1'b1; else stop_req = 1'b1;
            cycles(1);
            stop_req = 1'b0; wait_req = 1'b0;
            check(halt_clk == !VECS[k].is_wait, VECS[k].is_wait ? "R6 no halt in idle" : "R8 halt set",
                  halt_clk, !VECS[k].is_wait);
            cycles(2);
            irq_n = 1'b0;
            measure(2000, e);
            check(e == VECS[k].exp_edges, VECS[k].is_wait ? "R6 idle wake edges" : "R4 stop wake edges",
                  e, VECS[k].exp_edges);
            check(irq_take && !halt_clk, "R4 take and halt clear at fetch", {irq_take, halt_clk}, 2);
            cycles(1);
            check(!fetch_start, "R9 single pulse", fetch_start, 0);
            irq_n = 1'b1;
            cycles(6);
        end

        // R5 one-sample request in halted state is ignored
        stab_short = 1'b1; irq_edge = 1'b1;
        stop_req = 1'b1; wait_req = 1'b1;
        cycles(1);
        stop_req = 1'b0; wait_req = 1'b0;
        check(halt_clk, "R8 stop wins over wait", halt_clk, 1);
        irq_n = 1'b0;
        cycles(1);
        irq_n = 1'b1;
        pulses = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (fetch_start || !halt_clk) pulses++;
        end
        check(pulses == 0, "R5 short pulse ignored in stop", pulses, 0);
        check(halt_clk, "R5 still halted", halt_clk, 1);

        // R10 reset while halted, then R2 reboot count
        #1 rst_n = 1'b0;
        #1 check(!bus_en, "R1 bus off without edge", bus_en, 0);
        cycles(1);
        check(!halt_clk, "R10 halt cleared by reset", halt_clk, 1'b0);
        cycles(3);
        rst_n = 1'b1;
        measure(200, e);
        check(e == 33, "R2 boot after reset", e, 33);
        check(bus_en, "R1 bus on after boot", bus_en, 1);

        // R2 plain reset from run
        rst_n = 1'b0;
        cycles(4);
        check(!bus_en && !fetch_start, "R1 reset holds bus off", bus_en, 0);
        rst_n = 1'b1;
        measure(200, e);
        check(e == 33, "R2 boot after reset from run", e, 33);

        // R3 long power-on settling
        stab_short = 1'b0;
        por_n = 1'b0;
        cycles(2);
        check(!bus_en && !halt_clk, "R1 power-on state", bus_en, 0);
        por_n = 1'b1;
        measure(3000, e);
        check(e == LONG + 31, "R3 long por", e, LONG + 31);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule